// File: doc/BRIEF.md
# Serial Receive Path with Character Queue

This block is the receive half of an asynchronous serial port. A single serial line is sampled on a free-running oversampling tick (sixteen ticks per bit by default), each character is deframed into data, parity and stop fields, and the result is pushed into a small character queue together with four per-character error flags. The queue head is offered to the consumer on a valid/ready stream. One character is removed on each clock edge where valid and ready are both high. While valid is high and ready is low, the head character and its flags stay unchanged.

Level flags report whether the queue is close to full or has reached half occupancy. A request-to-send output, active low, is driven either from a control input or automatically from the queue's near-full level. A loopback select feeds the receiver from the local transmitter's serial output instead of the line pin. Character length, parity enable and parity sense are plain control inputs. The receiver is held idle and the queue is emptied while the enable input is low.

Top module: `serial_rx_queue`

## Requirements
- R1: While `rx_en` is low, the deframer stays idle, nothing is stored, and the queue is emptied: `out_valid` is 0 on the cycle after `rx_en` was sampled low.
- R2: `out_valid` is 1 exactly when the queue holds at least one character. While `out_valid` is 1 and `out_ready` is 0, `out_data` and the flags hold their value. A character is removed on each edge where both are 1.
- R3: With the default 12-entry queue, `fifo_full` is 1 when the occupancy is 11 or more (one free slot or fewer). `fifo_half` is 1 when four or fewer slots are free, which is an occupancy of 8 or more.
- R4: With `char8` = 1, all eight received data bits are delivered. With `char8` = 0, seven bits are received and `out_data[7]` is 0.
- R5: A frame with one valid high stop bit is accepted. Extra high stop bits are treated as line idle, and the next frame is received normally.
- R6: A character is flagged as a break (`out_brk`) when its data bits, its parity bit if parity is enabled, and its stop bit are all 0. A break always also sets `out_frm_err`. With odd parity, a break also sets `out_par_err`.
- R7: A stop bit sampled low sets `out_frm_err` for that character. After a low stop bit, the receiver waits for the line to return high before it looks for a new start bit.
- R8: With `par_en` = 1, `out_par_err` is set when the XOR of the data bits and the parity bit is 1 for even parity (`par_odd` = 0) or 0 for odd parity (`par_odd` = 1). With `par_en` = 0, `out_par_err` is 0.
- R9: A character that arrives while the queue holds 12 entries is dropped. The next stored character carries `out_ovr` = 1. Characters stored without a loss in between carry `out_ovr` = 0.
- R10: With `rts_auto` = 1, `rts_n` is 1 (negated) exactly while `fifo_full` is 1. With `rts_auto` = 0, `rts_n` is the inverse of `rts_req`.
- R11: With `loop_en` = 1, the receiver takes its input from `tx_loop`, and the level on `rxd` has no effect.
- R12: A start bit is confirmed half a bit time (8 ticks) after the falling edge is seen. A low pulse that has ended by then is discarded, and no character is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling strobe, one clock wide, OSR per bit |
| rxd | input | 1 | Serial line input pin |
| tx_loop | input | 1 | Serial output of the local transmitter, used in loopback |
| loop_en | input | 1 | Select `tx_loop` as the receiver input |
| rx_en | input | 1 | Receiver enable. Low empties the queue |
| char8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rts_auto | input | 1 | RTS follows the queue's near-full level |
| rts_req | input | 1 | Manual RTS request, used when `rts_auto` = 0 |
| out_valid | output | 1 | Queue head valid (data-ready flag) |
| out_ready | input | 1 | Consumer accepts the head |
| out_data | output | 8 | Head character |
| out_par_err | output | 1 | Parity error of the head character |
| out_frm_err | output | 1 | Framing error of the head character |
| out_brk | output | 1 | Head character is a break |
| out_ovr | output | 1 | A character was lost before the head was stored |
| fifo_full | output | 1 | One or no free slot remains |
| fifo_half | output | 1 | Four or fewer free slots remain |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The bench builds the block with its default parameters: a 12-entry queue, a near-half threshold of four free slots, and sixteen ticks per bit, with a tick every four clocks. The 12-entry depth keeps every occupancy step in reach, so each frame can be checked against the near-half flag at eight entries, the near-full flag and automatic RTS at eleven, the twelve-entry limit, and the overrun that follows a dropped character. Sixteen ticks per bit leave room for a start pulse three ticks long, which ends well before the mid-bit confirmation.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
    logic       ovr;
  } rx_char_t;
endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  logic     line,
  input  logic     char8,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     ch_valid,
  output rx_char_t ch
);
  localparam int CNTW = $clog2(OSR);
  localparam logic [CNTW-1:0] MID  = CNTW'(OSR / 2 - 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITH} st_t;

  st_t             st;
  logic            sync1, sync2;
  logic [CNTW-1:0] cnt;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic            pbit;

  // Assembled character, valid while the stop bit is being sampled.
  logic [7:0] data_c;
  logic       brk_c, perr_c;
  always_comb begin
    data_c = char8 ? sh : {1'b0, sh[7:1]};
    brk_c  = (data_c == 8'h00) && !(par_en && pbit) && !sync2;
    perr_c = par_en && ((^data_c ^ pbit) != par_odd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= line;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      pbit     <= 1'b0;
      ch_valid <= 1'b0;
      ch       <= '0;
    end else begin
      ch_valid <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!sync2) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == MID) begin
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            st   <= sync2 ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
          S_DATA: if (cnt == LAST) begin
            cnt  <= '0;
            sh   <= {sync2, sh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == (char8 ? 3'd7 : 3'd6)) st <= par_en ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (cnt == LAST) begin
            cnt  <= '0;
            pbit <= sync2;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (cnt == LAST) begin
            cnt      <= '0;
            ch_valid <= 1'b1;
            ch.data  <= data_c;
            ch.perr  <= perr_c;
            ch.ferr  <= !sync2;
            ch.brk   <= brk_c;
            ch.ovr   <= 1'b0;
            st       <= sync2 ? S_IDLE : S_WAITH;
          end else cnt <= cnt + 1'b1;
          S_WAITH: if (sync2) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int HALF_FREE = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     push,
  input  rx_char_t push_ch,
  input  logic     pop,
  output rx_char_t head,
  output logic     nonempty,
  output logic     near_full,
  output logic     near_half
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH - 1);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH - HALF_FREE);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);

  rx_char_t        mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;
  logic            lost;
  logic            do_pop, do_push;
  rx_char_t        wr_ch;

  always_comb begin
    do_pop    = pop && (count != '0);
    do_push   = push && ((count != CAP) || do_pop);
    wr_ch     = push_ch;
    wr_ch.ovr = lost;
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wr_ch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      lost   <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && !do_push) lost <= 1'b1;
      else if (do_push)     lost <= 1'b0;
    end
  end

  assign head      = mem[rd_ptr];
  assign nonempty  = (count != '0);
  assign near_full = (count >= FULL_LVL);
  assign near_half = (count >= HALF_LVL);
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DEPTH     = 12,
  parameter int HALF_FREE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       tx_loop,
  input  logic       loop_en,
  input  logic       rx_en,
  input  logic       char8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rts_auto,
  input  logic       rts_req,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_par_err,
  output logic       out_frm_err,
  output logic       out_brk,
  output logic       out_ovr,
  output logic       fifo_full,
  output logic       fifo_half,
  output logic       rts_n
);
  logic     line_in;
  logic     ch_valid;
  rx_char_t ch, head;

  assign line_in = loop_en ? tx_loop : rxd;

  rx_deframer #(.OSR(OSR)) u_deframe (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .line(line_in),
    .char8(char8), .par_en(par_en), .par_odd(par_odd),
    .ch_valid(ch_valid), .ch(ch)
  );

  rx_char_fifo #(.DEPTH(DEPTH), .HALF_FREE(HALF_FREE)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en),
    .push(ch_valid && rx_en), .push_ch(ch),
    .pop(out_valid && out_ready),
    .head(head), .nonempty(out_valid),
    .near_full(fifo_full), .near_half(fifo_half)
  );

  assign out_data    = head.data;
  assign out_par_err = head.perr;
  assign out_frm_err = head.ferr;
  assign out_brk     = head.brk;
  assign out_ovr     = head.ovr;

  // Pin is active low: automatic mode negates it at the near-full level.
  assign rts_n = rts_auto ? fifo_full : !rts_req;
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_brk,
  input logic       out_frm_err,
  input logic       fifo_full,
  input logic       fifo_half
);
  a_r1_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !out_valid);

  a_r2_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && rx_en |=> out_valid && $stable(out_data));

  a_r3_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> fifo_half);

  a_r6_break_framing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_brk |-> out_frm_err);
endmodule

bind serial_rx_queue serial_rx_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_brk(out_brk),
  .out_frm_err(out_frm_err), .fifo_full(fifo_full), .fifo_half(fifo_half)
);

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int OSR        = 16;
  localparam int BITCLK     = OSR * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic ln = 1'b1;
  logic use_loop = 1'b0;
  logic rxd, tx_loop;
  logic loop_en = 0, rx_en = 0, char8 = 1, par_en = 0, par_odd = 0;
  logic rts_auto = 0, rts_req = 0, out_ready = 0;
  logic out_valid, out_par_err, out_frm_err, out_brk, out_ovr;
  logic fifo_full, fifo_half, rts_n;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int tdiv_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv_cnt = (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick = (tdiv_cnt == 0);
  end

  // In loopback the pin is held low so that it would break framing if used.
  assign rxd     = use_loop ? 1'b0 : ln;
  assign tx_loop = use_loop ? ln : 1'b1;

  serial_rx_queue u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .tx_loop(tx_loop),
    .loop_en(loop_en), .rx_en(rx_en), .char8(char8), .par_en(par_en),
    .par_odd(par_odd), .rts_auto(rts_auto), .rts_req(rts_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err), .out_brk(out_brk),
    .out_ovr(out_ovr), .fifo_full(fifo_full), .fifo_half(fifo_half), .rts_n(rts_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic bit_time(input logic v);
    ln = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  // Frame: start, nb data bits LSB first, optional parity, stop level, idle bit.
  task automatic send_frame(input logic [7:0] d, input int nb, input bit with_par,
                            input logic pbit, input logic stopv);
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) bit_time(d[i]);
    if (with_par) bit_time(pbit);
    bit_time(stopv);
    bit_time(1'b1);
  endtask

  task automatic pop_one();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic flush_q();
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R2", "out_valid after reset", out_valid, 0);
    chk_eq("R3", "fifo_full after reset", fifo_full, 0);
    chk_eq("R3", "fifo_half after reset", fifo_half, 0);
    chk_eq("R10", "rts_n manual req=0", rts_n, 1);
  endtask

  task automatic t_basic8();
    send_frame(8'hA5, 8, 0, 0, 1);
    chk_eq("R2", "valid after frame", out_valid, 1);
    chk_eq("R4", "8-bit data", out_data, 8'hA5);
    chk_eq("R8", "parity off no perr", out_par_err, 0);
    chk_eq("R7", "no frame err", out_frm_err, 0);
    repeat (20) @(negedge clk);
    chk_eq("R2", "head held while not ready", out_data, 8'hA5);
    pop_one();
    chk_eq("R2", "empty after pop", out_valid, 0);
  endtask

  task automatic t_seven_bit();
    char8 = 1'b0;
    send_frame(8'hFF, 7, 0, 0, 1);
    chk_eq("R4", "7-bit msb cleared", out_data, 8'h7F);
    pop_one();
    char8 = 1'b1;
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h03, 8, 1, 1'b0, 1);       // even, correct parity bit
    chk_eq("R8", "even ok perr", out_par_err, 0);
    chk_eq("R8", "even ok data", out_data, 8'h03);
    pop_one();
    send_frame(8'h07, 8, 1, 1'b0, 1);       // even, wrong parity bit
    chk_eq("R8", "even bad perr", out_par_err, 1);
    pop_one();
    par_odd = 1'b1;
    send_frame(8'h07, 8, 1, 1'b0, 1);       // odd, correct parity bit
    chk_eq("R8", "odd ok perr", out_par_err, 0);
    pop_one();
    par_en = 1'b0;
  endtask

  task automatic t_frame_err();
    send_frame(8'h5A, 8, 0, 0, 0);
    chk_eq("R7", "missing stop ferr", out_frm_err, 1);
    chk_eq("R6", "nonzero data no brk", out_brk, 0);
    chk_eq("R7", "data kept", out_data, 8'h5A);
    pop_one();
    send_frame(8'h33, 8, 0, 0, 1);
    chk_eq("R7", "recovers after ferr", out_data, 8'h33);
    chk_eq("R7", "next ferr clear", out_frm_err, 0);
    pop_one();
  endtask

  task automatic t_break();
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h00, 8, 1, 1'b0, 0);
    chk_eq("R6", "even break brk", out_brk, 1);
    chk_eq("R6", "even break ferr", out_frm_err, 1);
    chk_eq("R6", "even break perr", out_par_err, 0);
    pop_one();
    par_odd = 1'b1;
    send_frame(8'h00, 8, 1, 1'b0, 0);
    chk_eq("R6", "odd break brk", out_brk, 1);
    chk_eq("R6", "odd break perr", out_par_err, 1);
    pop_one();
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_two_stop();
    bit_time(1'b1);                          // extra stop bit before next
    send_frame(8'h81, 8, 0, 0, 1);
    bit_time(1'b1);
    send_frame(8'h18, 8, 0, 0, 1);
    chk_eq("R5", "first after long stop", out_data, 8'h81);
    pop_one();
    chk_eq("R5", "second after long stop", out_data, 8'h18);
    chk_eq("R5", "no ferr", out_frm_err, 0);
    pop_one();
  endtask

  task automatic t_glitch();
    ln = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    ln = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk_eq("R12", "glitch not stored", out_valid, 0);
    send_frame(8'hC3, 8, 0, 0, 1);
    chk_eq("R12", "frame after glitch", out_data, 8'hC3);
    pop_one();
  endtask

  task automatic t_loopback();
    use_loop = 1'b1; loop_en = 1'b1;
    send_frame(8'h6E, 8, 0, 0, 1);
    chk_eq("R11", "loopback data", out_data, 8'h6E);
    chk_eq("R11", "rxd ignored no ferr", out_frm_err, 0);
    pop_one();
    chk_eq("R11", "single char only", out_valid, 0);
    use_loop = 1'b0; loop_en = 1'b0;
  endtask

  task automatic t_fill_overrun();
    rts_auto = 1'b1;
    for (int i = 0; i < 12; i++) begin
      send_frame(8'(8'h10 + i), 8, 0, 0, 1);
      if (i == 6) chk_eq("R3", "half at 7", fifo_half, 0);
      if (i == 7) chk_eq("R3", "half at 8", fifo_half, 1);
      if (i == 9) begin
        chk_eq("R3", "full at 10", fifo_full, 0);
        chk_eq("R10", "rts asserted at 10", rts_n, 0);
      end
      if (i == 10) begin
        chk_eq("R3", "full at 11", fifo_full, 1);
        chk_eq("R10", "rts negated at 11", rts_n, 1);
      end
    end
    send_frame(8'hEE, 8, 0, 0, 1);          // dropped
    chk_eq("R9", "head after drop", out_data, 8'h10);
    chk_eq("R9", "head no ovr", out_ovr, 0);
    pop_one();
    send_frame(8'h77, 8, 0, 0, 1);          // stored with overrun mark
    for (int i = 0; i < 11; i++) begin
      if (i == 1) chk_eq("R9", "earlier char no ovr", out_ovr, 0);
      pop_one();
    end
    chk_eq("R9", "char after loss", out_data, 8'h77);
    chk_eq("R9", "ovr flag", out_ovr, 1);
    pop_one();
    send_frame(8'h44, 8, 0, 0, 1);
    chk_eq("R9", "ovr cleared next", out_ovr, 0);
    pop_one();
    rts_auto = 1'b0;
    rts_req = 1'b1;
    @(negedge clk);
    chk_eq("R10", "manual req=1", rts_n, 0);
    rts_req = 1'b0;
  endtask

  task automatic t_disable();
    send_frame(8'h21, 8, 0, 0, 1);
    send_frame(8'h22, 8, 0, 0, 1);
    chk_eq("R1", "two stored", out_valid, 1);
    rx_en = 1'b0;
    @(negedge clk);
    chk_eq("R1", "emptied on disable", out_valid, 0);
    send_frame(8'h23, 8, 0, 0, 1);
    chk_eq("R1", "nothing stored while off", out_valid, 0);
    rx_en = 1'b1;
    @(negedge clk);
    chk_eq("R1", "still empty on enable", out_valid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    t_basic8();
    t_seven_bit();
    t_parity();
    t_frame_err();
    t_break();
    t_two_stop();
    t_glitch();
    t_loopback();
    flush_q();
    t_fill_overrun();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule